// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the address that one port of a synchronous memory uses on each clock. At every rising edge it picks one of four sources for its address register: a fixed zero, a fresh address from the port pins, the current value plus one, or the current value unchanged. The register output is the address that the memory array uses in the cycle that follows the edge. A host can issue one explicit address and then stream a burst by holding the count enable low, stall the burst, or jump back to location zero without losing a cycle.

The three controls are active low and have a fixed priority. Clear comes first, then the address strobe, then the count enable. The sequencer does not look at chip enables or byte selects. It keeps counting while the memory is deselected, and a clear cycle is itself a usable access to address zero. The address bus carries control and not a data stream, so the block has no valid/ready handshake and does not apply back-pressure. The address changes on every edge on which the controls ask for a change.

Top module: `burst_addr_seq`

## Requirements
- R1: When `clr_n` is low at a rising edge, `addr` is 0 after that edge, whatever `strobe_n`, `step_n` and `ext_addr` are.
- R2: When `clr_n` is high and `strobe_n` is low at an edge, `addr` equals the `ext_addr` sampled at that edge, starting in the cycle right after it.
- R3: When `clr_n`, `strobe_n` and `step_n` are all high at an edge, `addr` keeps its value, and a change on `ext_addr` has no effect on it.
- R4: When `clr_n` and `strobe_n` are high and `step_n` is low at an edge, `addr` becomes its previous value plus one.
- R5: A step from the all-ones address (0x3FFF at the default 14-bit width) wraps `addr` to 0.
- R6: When `rst_n` is low at an edge, `addr` is 0 after that edge. This reset is synchronous.
- R7: When `strobe_n` and `step_n` are both low and `clr_n` is high, the load wins and `addr` takes `ext_addr` with no increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| ext_addr | input | ADDR_W (14) | External address presented by the host |
| strobe_n | input | 1 | Address strobe, active low: load `ext_addr` |
| step_n | input | 1 | Count enable, active low: advance by one |
| clr_n | input | 1 | Counter clear, active low: force address 0 |
| addr | output | ADDR_W (14) | Internal address used by the array this cycle |

## Verification
The hardest case to reach from the ports is the wrap from all ones to zero. A plain count from reset would need 16K steps to reach it. The stimulus instead loads an address just below the top with the strobe and then steps across the boundary. The priority corners, where clear, strobe and step are asserted together in several combinations, are driven directly. A long pseudo-random control sequence follows, in which `ext_addr` changes every cycle so that holds are tested against a moving external bus.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    SEL_KEEP = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_INCR = 2'd2,
    SEL_ZERO = 2'd3
  } addr_sel_e;
endpackage

// File: rtl/burst_sel_decode.sv
module burst_sel_decode
  import burst_addr_pkg::*;
(
  input  logic      clr_n,
  input  logic      strobe_n,
  input  logic      step_n,
  output addr_sel_e sel
);
  // fixed priority: clear, then strobe, then step
  always_comb begin
    if (!clr_n)         sel = SEL_ZERO;
    else if (!strobe_n) sel = SEL_LOAD;
    else if (!step_n)   sel = SEL_INCR;
    else                sel = SEL_KEEP;
  end
endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  addr_sel_e          sel,
  input  logic [ADDR_W-1:0]  cur,
  input  logic [ADDR_W-1:0]  ext,
  output logic [ADDR_W-1:0]  nxt
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_comb begin
    unique case (sel)
      SEL_ZERO: nxt = '0;
      SEL_LOAD: nxt = ext;
      SEL_INCR: nxt = cur + ONE;   // natural wrap at all ones
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_n,
  input  logic              step_n,
  input  logic              clr_n,
  output logic [ADDR_W-1:0] addr
);
  addr_sel_e         sel;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;

  burst_sel_decode u_dec (
    .clr_n    (clr_n),
    .strobe_n (strobe_n),
    .step_n   (step_n),
    .sel      (sel)
  );

  burst_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
    .sel (sel),
    .cur (addr_q),
    .ext (ext_addr),
    .nxt (addr_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              strobe_n,
  input logic              step_n,
  input logic              clr_n,
  input logic [ADDR_W-1:0] addr
);
  a_r1_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> addr == '0);

  a_r2_load_ext: assert property (@(posedge clk) disable iff (!rst_n)
    clr_n && !strobe_n |=> addr == $past(ext_addr));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    clr_n && strobe_n && step_n |=> $stable(addr));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    clr_n && strobe_n && !step_n |=> addr == ADDR_W'($past(addr) + 1'b1));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    clr_n && strobe_n && !step_n && (&addr) |=> addr == '0);

  a_r6_por: assert property (@(posedge clk)
    !rst_n |=> addr == '0);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ext_addr (ext_addr),
  .strobe_n (strobe_n),
  .step_n   (step_n),
  .clr_n    (clr_n),
  .addr     (addr)
);

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;
  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          strobe_n = 1'b1;
  logic          step_n = 1'b1;
  logic          clr_n = 1'b1;
  logic [AW-1:0] addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [AW-1:0] model = '0;
  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
    .strobe_n(strobe_n), .step_n(step_n), .clr_n(clr_n), .addr(addr)
  );

  // driver: apply one cycle of controls and push the expected address
  task automatic drive(input logic rn, input logic cn, input logic sn,
                       input logic tn, input logic [AW-1:0] ea,
                       input string tag);
    @(negedge clk);
    rst_n = rn; clr_n = cn; strobe_n = sn; step_n = tn; ext_addr = ea;
    if (!rn)      model = '0;
    else if (!cn) model = '0;
    else if (!sn) model = ea;
    else if (!tn) model = model + 1'b1;
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  // monitor: compare just after each edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [AW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (addr !== e) begin
        errors++;
        $display("FAIL %s: addr=%h expected=%h", t, addr, e);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    // R6: reset state
    drive(0, 1, 0, 0, 14'h0ABC, "R6");
    drive(0, 1, 1, 1, 14'h0111, "R6");
    // R2: load
    drive(1, 1, 0, 1, 14'h1234, "R2");
    // R3: hold with moving ext bus
    drive(1, 1, 1, 1, 14'h3333, "R3");
    drive(1, 1, 1, 1, 14'h0001, "R3");
    // R4: step
    for (int i = 0; i < 4; i++) drive(1, 1, 1, 0, 14'h2222, "R4");
    // R7: strobe and step both low -> load only
    drive(1, 1, 0, 0, 14'h0500, "R7");
    drive(1, 1, 1, 1, 14'h0000, "R7");
    // R5: wrap
    drive(1, 1, 0, 1, 14'h3FFE, "R5");
    drive(1, 1, 1, 0, 14'h0000, "R5");
    drive(1, 1, 1, 0, 14'h1111, "R5");
    drive(1, 1, 1, 0, 14'h1111, "R5");
    // R1: clear wins over strobe and step
    drive(1, 1, 0, 1, 14'h2AAA, "R2");
    drive(1, 0, 0, 0, 14'h1555, "R1");
    drive(1, 1, 1, 0, 14'h1555, "R4");
    drive(1, 0, 1, 0, 14'h1555, "R1");
    drive(1, 0, 0, 1, 14'h3FFF, "R1");
    // R6: reset mid-run
    drive(1, 1, 0, 1, 14'h0777, "R2");
    drive(0, 1, 1, 0, 14'h0777, "R6");
    // mixed pseudo-random sequence
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(1, (lfsr[3:0] != 4'd0), (lfsr[6:4] != 3'd0), lfsr[7],
            {lfsr[1:0], lfsr[15:4]}, "R3");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule